// File: doc/BRIEF.md
# Transform Coefficient Variance Collector

This block gathers second-order statistics over a group of three-dimensional transform cubes. Each beat on the input carries one signed coefficient and its position inside the cube. For every position the block keeps a running sum of the squared coefficient in an accumulator memory that has one entry per position. The coefficients are known to have zero mean, so no mean is subtracted. A block ends on the beat at the highest position, and the block counter advances there.

When a final block is seen, the block stops taking input. It then divides each position's sum by the number of blocks in the group, using one iterative divider that serves every position in turn. The variances come out one per pulse, in ascending position order, and a later stage uses them to design adaptive quantizers. After the read-out ends, the next beat that arrives starts a fresh group, and the first block of that group overwrites the old sums instead of adding to them.

Top module: `coef_var_accum`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_done` are low.
- R2: For each position the block sums the squares of all accepted coefficients at that position. With NPOS=512 and MAX_BLOCKS=64, a group of 64 blocks in which every coefficient is -8192 gives a sum of 2^32 with no wrap, so the variance read out is 2^26.
- R3: Each `out_var` equals floor(sum of squares at that position / number of blocks in the group).
- R4: The first block of a group replaces the sums left by the previous group. A group never includes data from earlier groups.
- R5: The read-out gives exactly one `out_valid` pulse per position. `out_pos` runs 0, 1, …, NPOS-1 in order.
- R6: `out_done` is high in the same cycle as the `out_valid` pulse for position NPOS-1, and in no other cycle.
- R7: `busy` rises in the cycle after the final beat of a group is accepted. It falls in the same cycle as `out_done`. Beats presented while `busy` is high are ignored, including beats that carry `in_last`.
- R8: When the same position is presented on back-to-back beats, every beat is added, so a position sent three times in a row adds all three squares.
- R9: A beat at position NPOS-1 closes a block. `in_last` takes effect only on such a beat, where it closes the group. `in_last` on any other position has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient beat present |
| in_coef | input | COEF_W | Signed coefficient |
| in_pos | input | POS_W | Position within the cube |
| in_last | input | 1 | Beat belongs to the final block of the group |
| busy | output | 1 | Read-out in progress; input ignored |
| out_valid | output | 1 | Variance output valid |
| out_pos | output | POS_W | Position of the variance output |
| out_var | output | ACC_W | Variance (mean of squares) |
| out_done | output | 1 | Last variance of the group |

## Verification
The stimulus uses four kinds of group, and each one isolates a different fault:
- **Three blocks with position-dependent values.** `in_last` is sprinkled on middle positions of one block. This exposes a wrong divisor, a wrong square, or an early group end.
- **A single block at full negative scale.** This shows whether stale sums from the previous group survive and whether the sign is handled when squaring.
- **Sixty-four full-scale blocks.** This reaches the accumulator's widest value.
- **Blocks with repeated positions on adjacent beats.** These are the only beats that need the write-to-read forwarding, so they expose a missing or wrong forward.

Junk beats, including a group-closing one, are driven during a read-out. These must leave the variances still being output untouched.

// File: rtl/cva_pkg.sv
package cva_pkg;
  typedef enum logic [1:0] {
    ST_ACC  = 2'd0,
    ST_RREQ = 2'd1,
    ST_RDAT = 2'd2,
    ST_DIV  = 2'd3
  } cva_state_t;
endpackage

// File: rtl/cva_acc_mem.sv
module cva_acc_mem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 34,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read returns the value held before a write in the same cycle
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cva_div.sv
module cva_div #(
  parameter int DVD_W = 34,
  parameter int DVS_W = 7,
  localparam int CW = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic             done,
  output logic [DVD_W-1:0] quo
);
  logic [DVS_W-1:0] rem;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] dvd_q;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DVS_W:0]   shifted;
  logic             fits;

  assign shifted = {rem, quo[DVD_W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= dvd;
        dvd_q <= dvd;
        dvs_q <= dvs;
        rem   <= '0;
        cnt   <= CW'(DVD_W);
        run   <= 1'b1;
      end else if (run) begin
        if (fits) rem <= DVS_W'(shifted - {1'b0, dvs_q});
        else      rem <= shifted[DVS_W-1:0];
        quo <= {quo[DVD_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  localparam int PW = DVD_W + DVS_W;
  logic [PW-1:0] chk_prod;
  assign chk_prod = PW'(quo) * PW'(dvs_q);

  // R3: quotient is the floor of dividend over divisor
  a_r3_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_prod <= PW'(dvd_q)) && (PW'(dvd_q) - chk_prod < PW'(dvs_q)));
endmodule

// File: rtl/coef_var_accum.sv
module coef_var_accum #(
  parameter int COEF_W     = 14,
  parameter int NPOS       = 512,
  parameter int MAX_BLOCKS = 64,
  localparam int POS_W = $clog2(NPOS),
  localparam int CNT_W = $clog2(MAX_BLOCKS + 1),
  localparam int ACC_W = 2 * COEF_W - 1 + CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [COEF_W-1:0] in_coef,
  input  logic [POS_W-1:0]         in_pos,
  input  logic                     in_last,
  output logic                     busy,
  output logic                     out_valid,
  output logic [POS_W-1:0]         out_pos,
  output logic [ACC_W-1:0]         out_var,
  output logic                     out_done
);
  import cva_pkg::*;

  localparam logic [POS_W-1:0] TOP_POS = POS_W'(NPOS - 1);

  function automatic logic [ACC_W-1:0] coef_sq(input logic signed [COEF_W-1:0] c);
    logic [COEF_W-1:0] mag;
    mag = c[COEF_W-1] ? COEF_W'(-c) : COEF_W'(c);
    return ACC_W'(mag) * ACC_W'(mag);
  endfunction

  cva_state_t state;

  logic             s1_valid, s1_last;
  logic [POS_W-1:0] s1_pos;
  logic [ACC_W-1:0] s1_sq;
  logic             pw_valid;
  logic [POS_W-1:0] pw_pos;
  logic [ACC_W-1:0] pw_data;
  logic             first_blk;
  logic [CNT_W-1:0] blk_cnt, n_blk;
  logic [POS_W-1:0] rd_ptr;

  logic             accept, blk_end, grp_end, fwd_hit, wr_en;
  logic [ACC_W-1:0] acc_old, wr_data, mem_rdata, div_quo;
  logic [POS_W-1:0] mem_raddr;
  logic             div_start, div_done;

  assign blk_end   = s1_valid && (s1_pos == TOP_POS);
  assign grp_end   = blk_end && s1_last;
  assign busy      = (state != ST_ACC) || grp_end;
  assign accept    = in_valid && !busy;
  assign fwd_hit   = pw_valid && (pw_pos == s1_pos);
  assign acc_old   = fwd_hit ? pw_data : (first_blk ? '0 : mem_rdata);
  assign wr_en     = s1_valid;
  assign wr_data   = acc_old + s1_sq;
  assign mem_raddr = (state == ST_ACC) ? in_pos : rd_ptr;
  assign div_start = (state == ST_RDAT);

  cva_acc_mem #(.DEPTH(NPOS), .WIDTH(ACC_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(s1_pos), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  cva_div #(.DVD_W(ACC_W), .DVS_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dvd(mem_rdata),
    .dvs(n_blk), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_ACC;
      s1_valid  <= 1'b0;
      s1_last   <= 1'b0;
      s1_pos    <= '0;
      s1_sq     <= '0;
      pw_valid  <= 1'b0;
      pw_pos    <= '0;
      pw_data   <= '0;
      first_blk <= 1'b1;
      blk_cnt   <= '0;
      n_blk     <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      out_pos   <= '0;
      out_var   <= '0;
    end else begin
      s1_valid  <= accept;
      s1_pos    <= in_pos;
      s1_sq     <= coef_sq(in_coef);
      s1_last   <= in_last;
      pw_valid  <= wr_en;
      pw_pos    <= s1_pos;
      pw_data   <= wr_data;
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      if (blk_end) begin
        first_blk <= 1'b0;
        blk_cnt   <= blk_cnt + 1'b1;
      end
      case (state)
        ST_ACC: if (grp_end) begin
          n_blk  <= blk_cnt + 1'b1;
          rd_ptr <= '0;
          state  <= ST_RREQ;
        end
        ST_RREQ: state <= ST_RDAT;
        ST_RDAT: state <= ST_DIV;
        ST_DIV: if (div_done) begin
          out_valid <= 1'b1;
          out_pos   <= rd_ptr;
          out_var   <= div_quo;
          if (rd_ptr == TOP_POS) begin
            out_done  <= 1'b1;
            first_blk <= 1'b1;
            blk_cnt   <= '0;
            state     <= ST_ACC;
          end else begin
            rd_ptr <= rd_ptr + 1'b1;
            state  <= ST_RREQ;
          end
        end
        default: state <= ST_ACC;
      endcase
    end
  end

  logic [POS_W-1:0] last_out_pos;
  always_ff @(posedge clk) begin
    if (!rst_n)         last_out_pos <= '0;
    else if (out_valid) last_out_pos <= out_pos;
  end

  // R2: an accumulate never wraps below the value it started from
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data >= acc_old);
  // R5: positions are read out in ascending order
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pos != '0) |-> out_pos == last_out_pos + 1'b1);
  // R6: the done marker comes only with the top position
  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_valid && out_pos == TOP_POS));
  // R7: a beat offered while busy never enters the pipeline
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> !s1_valid);
endmodule

// File: tb/coef_var_accum_test.sv
module coef_var_accum_test;
  localparam int COEF_W = 14;
  localparam int NPOS   = 512;
  localparam int MAXB   = 64;
  localparam int POS_W  = 9;
  localparam int ACC_W  = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [COEF_W-1:0] in_coef = '0;
  logic [POS_W-1:0] in_pos = '0;
  logic in_last = 1'b0;
  logic busy, out_valid, out_done;
  logic [POS_W-1:0] out_pos;
  logic [ACC_W-1:0] out_var;

  always #4 clk = ~clk;

  coef_var_accum #(.COEF_W(COEF_W), .NPOS(NPOS), .MAX_BLOCKS(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .in_pos(in_pos), .in_last(in_last), .busy(busy), .out_valid(out_valid),
    .out_pos(out_pos), .out_var(out_var), .out_done(out_done)
  );

  int checks = 0;
  int fails  = 0;
  longint sums [NPOS];
  longint exp_var [NPOS];
  int nblk = 0;
  int exp_ptr = 0;
  bit exp_busy = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: capture accepted beats at the edge
  always @(posedge clk) begin
    if (rst_n && in_valid && !exp_busy) begin
      longint c;
      c = longint'(in_coef);
      sums[in_pos] += c * c;
      if (in_pos == POS_W'(NPOS - 1)) begin
        nblk++;
        if (in_last) begin
          for (int p = 0; p < NPOS; p++) begin
            exp_var[p] = sums[p] / nblk;
            sums[p] = 0;
          end
          nblk = 0;
          exp_ptr = 0;
          exp_busy = 1'b1;
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        check(exp_busy, "R7 output outside read-out", 1, 0);
        check(out_pos == POS_W'(exp_ptr), "R5 position order", out_pos, exp_ptr);
        check(out_var == ACC_W'(exp_var[exp_ptr]), "R3/R2 variance", out_var, exp_var[exp_ptr]);
        check(out_done == (exp_ptr == NPOS - 1), "R6 done marker", out_done, exp_ptr == NPOS - 1);
        if (exp_ptr == NPOS - 1) exp_busy = 1'b0;
        exp_ptr++;
      end else begin
        check(!out_done, "R6 done without output", out_done, 0);
      end
      check(busy == exp_busy, "R7 busy", busy, exp_busy);
    end
  end

  task automatic beat(input int pos, input int coef, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_pos   = POS_W'(pos);
    in_coef  = COEF_W'(coef);
    in_last  = last;
  endtask

  task automatic idle_wait();
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (exp_busy) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < NPOS; p++) sums[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !out_done, "R1 reset state",
          {busy, out_valid, out_done}, 0);

    // group A: 3 blocks, varied values; stray in_last mid-block (R9)
    for (int b = 0; b < 3; b++)
      for (int p = 0; p < NPOS; p++)
        beat(p, ((p * 37 + b * 101) % 16384) - 8192, (b == 2) || (b == 1 && p == 100));
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    // junk during read-out, including a group-closing beat (R7)
    for (int k = 0; k < 20; k++) beat((k * 29) % NPOS, 8191, 1'b1);
    beat(NPOS - 1, -8192, 1'b1);
    idle_wait();

    // group B: one block at full negative scale, clears group A (R4)
    for (int p = 0; p < NPOS; p++) beat(p, -8192 + (p % 3), 1'b1);
    idle_wait();

    // group C: 64 full-scale blocks, widest sum (R2)
    for (int b = 0; b < MAXB; b++)
      for (int p = 0; p < NPOS; p++) beat(p, -8192, b == MAXB - 1);
    idle_wait();

    // group D: back-to-back repeats of one position (R8)
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < NPOS; p++) begin
        beat(p, p - 256 + b, b == 1);
        if (p == 7) begin
          beat(7, 1000, 1'b0);
          beat(7, -3000, 1'b0);
        end
        if (p == 300) beat(300, 4095, 1'b0);
      end
    idle_wait();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    finished = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule